// File: doc/BRIEF.md
# Multi-Cycle CPU Control Sequencer

This block is the control unit of a 16-bit CPU that runs each instruction over several clocks. It keeps two pieces of state: a phase flag that says whether an instruction is being fetched, and a 4-bit cycle counter. Every clock it looks up a 25-bit control word. The lookup address is the phase flag, the cycle counter and the low five bits of the current opcode. The fields of that word drive the datapath's write strobes, source selects and ALU function.

An instruction is two 16-bit words. Fetch always takes four cycles: load the instruction register from memory at PC, step PC by one, load the operand register from memory at PC, then step PC again. The counter is not cleared when fetch ends, so execution starts at cycle 4. Three instructions are sequenced:

- a load-word, which forms an address with the ALU and writes memory data back to the register file;
- a register-to-register add;
- a halt, which freezes the unit until reset.

Any other address of the lookup yields a recovery word that restarts fetch, so the unit cannot hang.

Top module: `ctl_sequencer`

## Requirements
- R1: After synchronous reset the phase flag (`phase_fetch_o`) is 1, the cycle counter (`cycle_o`) is 0 and no halt is held.
- R2: In fetch phase at cycle 0 the word asserts `ir_we_o` and `fetch_next_o`, with `addr_sel_o`=0 (memory addressed by PC); every other field is 0.
- R3: In fetch phase, cycle 1 drives `pc_wr_o`=01 (PC+1) with `fetch_next_o`=1; cycle 2 asserts `opnd_we_o` and `fetch_next_o` with `addr_sel_o`=0; cycle 3 drives `pc_wr_o`=01 with `fetch_next_o`=0. All other fields are 0.
- R4: The cycle counter rises by one every clock unless the word asserts `cyc_clr_o`, which sends it to 0. The phase flag takes `fetch_next_o` at each clock, so execution starts at cycle 4 with the phase flag at 0.
- R5: Load-word (opcode low bits 11001), in execute phase:
  - cycle 4 asserts `res_we_o` with `alu_fn_o`=0000 (add) and `alub_sel_o`=1 (operand register);
  - cycle 5 asserts `addr_sel_o`=1, `wb_sel_o`=101 (memory data), `rf_we_o`, `cyc_clr_o` and `fetch_next_o`;
  - the next cycle is fetch cycle 0.
- R6: Register add (opcode low bits 00000), in execute phase:
  - cycle 4 asserts `res_we_o` with `alu_fn_o`=0000 and `alub_sel_o`=0;
  - cycle 5 asserts `rf_we_o` with `wb_sel_o`=000 (result path), `cyc_clr_o` and `fetch_next_o`;
  - the next cycle is fetch cycle 0.
- R7: While in fetch phase the opcode input has no effect on any output.
- R8: Halt (opcode low bits 11111) at execute cycle 4 asserts `stop_o` with every other field 0. From then on `stop_o` stays 1, every strobe stays 0, and the cycle counter and phase flag stay frozen until reset.
- R9: Any other combination gives `cyc_clr_o`=1 and `fetch_next_o`=1, with every other field 0, so the next cycle is fetch cycle 0.
- R10: `ctl_word_o` packs the fields MSB first:
  - bit 24 stop, bit 23 cycle clear, bit 22 next-fetch;
  - bits 21:20 PC source, bits 19:18 PC write;
  - bit 17 address select, bit 16 memory write, bit 15 instruction-register write, bit 14 operand-register write;
  - bits 13:11 write-back select, bit 10 register-file write, bit 9 ALU-B select, bit 8 second-read select;
  - bits 7:4 ALU function, bit 3 result write, bit 2 low write, bit 1 high write;
  - bit 0 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 5 | Low bits of the instruction register's opcode field |
| stop_o | output | 1 | Halt the CPU |
| cyc_clr_o | output | 1 | Clear the cycle counter |
| fetch_next_o | output | 1 | Phase flag value for the next cycle |
| pc_sel_o | output | 2 | PC source select |
| pc_wr_o | output | 2 | PC write control (01 = PC+1) |
| addr_sel_o | output | 1 | Memory address source (0 PC, 1 result) |
| mem_we_o | output | 1 | Memory write |
| ir_we_o | output | 1 | Instruction register write |
| opnd_we_o | output | 1 | Operand register write |
| wb_sel_o | output | 3 | Register-file write-data select |
| rf_we_o | output | 1 | Register-file write |
| alub_sel_o | output | 1 | ALU B input select (1 = operand register) |
| rd2_sel_o | output | 1 | Second read-port address select |
| alu_fn_o | output | 4 | ALU function |
| res_we_o | output | 1 | Result register write |
| lo_we_o | output | 1 | Low product/quotient register write |
| hi_we_o | output | 1 | High product/quotient register write |
| ctl_word_o | output | 25 | Whole control word |
| phase_fetch_o | output | 1 | Current phase flag (1 = fetching) |
| cycle_o | output | 4 | Current cycle counter |

## Verification
The assertions assume that the opcode input is stable and known whenever the unit is in execute phase, because the datapath's instruction register is written only at fetch cycle 0. The stimulus holds one opcode through a whole instruction and changes it only right after reset. It sweeps all 32 opcode values and follows each one through fetch, execute and recovery or halt. Cycles 6 to 15 of execute and cycles 4 to 15 of fetch cannot be reached from reset, so the assertions on counter movement cover them only as states with no successor.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

    localparam int OPC_W  = 5;
    localparam int T_W    = 4;
    localparam int WORD_W = 25;

    typedef struct packed {
        logic       stop;
        logic       cyc_clr;
        logic       fetch_next;
        logic [1:0] pc_sel;
        logic [1:0] pc_wr;
        logic       addr_sel;
        logic       mem_we;
        logic       ir_we;
        logic       opnd_we;
        logic [2:0] wb_sel;
        logic       rf_we;
        logic       alub_sel;
        logic       rd2_sel;
        logic [3:0] alu_fn;
        logic       res_we;
        logic       lo_we;
        logic       hi_we;
        logic       spare;
    } ctl_t;

    localparam logic [OPC_W-1:0] OPC_ADD  = 5'b00000;
    localparam logic [OPC_W-1:0] OPC_LW   = 5'b11001;
    localparam logic [OPC_W-1:0] OPC_HALT = 5'b11111;

    localparam logic [1:0] PCW_INC   = 2'b01;
    localparam logic [2:0] WB_RESULT = 3'b000;
    localparam logic [2:0] WB_MEM    = 3'b101;
    localparam logic [3:0] FN_ADD    = 4'b0000;

    localparam logic [T_W-1:0] EXEC_T0 = 4'd4;
    localparam logic [T_W-1:0] EXEC_T1 = 4'd5;

    function automatic ctl_t ctl_recover();
        ctl_t w = '0;
        w.cyc_clr    = 1'b1;
        w.fetch_next = 1'b1;
        return w;
    endfunction

    function automatic ctl_t ctl_halt();
        ctl_t w = '0;
        w.stop = 1'b1;
        return w;
    endfunction

    function automatic ctl_t fetch_word(input logic [T_W-1:0] t);
        ctl_t w = '0;
        case (t)
            4'd0: begin
                w.ir_we      = 1'b1;
                w.addr_sel   = 1'b0;
                w.fetch_next = 1'b1;
            end
            4'd1: begin
                w.pc_wr      = PCW_INC;
                w.fetch_next = 1'b1;
            end
            4'd2: begin
                w.opnd_we    = 1'b1;
                w.addr_sel   = 1'b0;
                w.fetch_next = 1'b1;
            end
            4'd3: begin
                w.pc_wr      = PCW_INC;
                w.fetch_next = 1'b0;
            end
            default: w = ctl_recover();
        endcase
        return w;
    endfunction

    function automatic ctl_t exec_word(input logic [T_W-1:0] t,
                                       input logic [OPC_W-1:0] op);
        ctl_t w = ctl_recover();
        if (op == OPC_LW) begin
            if (t == EXEC_T0) begin
                w          = '0;
                w.res_we   = 1'b1;
                w.alu_fn   = FN_ADD;
                w.alub_sel = 1'b1;
            end else if (t == EXEC_T1) begin
                w          = ctl_recover();
                w.addr_sel = 1'b1;
                w.wb_sel   = WB_MEM;
                w.rf_we    = 1'b1;
            end
        end else if (op == OPC_ADD) begin
            if (t == EXEC_T0) begin
                w          = '0;
                w.res_we   = 1'b1;
                w.alu_fn   = FN_ADD;
                w.alub_sel = 1'b0;
            end else if (t == EXEC_T1) begin
                w        = ctl_recover();
                w.wb_sel = WB_RESULT;
                w.rf_we  = 1'b1;
            end
        end else if (op == OPC_HALT) begin
            if (t == EXEC_T0) w = ctl_halt();
        end
        return w;
    endfunction

    function automatic ctl_t decode(input logic fetch,
                                    input logic [T_W-1:0] t,
                                    input logic [OPC_W-1:0] op);
        if (fetch) return fetch_word(t);
        return exec_word(t, op);
    endfunction

endpackage

// File: rtl/ctl_rom.sv
module ctl_rom
    import seqctl_pkg::*;
#(
    parameter bit USE_TABLE = 1'b1
) (
    input  logic             fetch,
    input  logic [T_W-1:0]   cyc,
    input  logic [OPC_W-1:0] op,
    output ctl_t             word
);
    localparam int ADDR_W = 1 + T_W + OPC_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [ADDR_W-1:0] addr;
    assign addr = {fetch, cyc, op};

    generate
        if (USE_TABLE) begin : g_table
            ctl_t tbl [DEPTH];
            for (genvar i = 0; i < DEPTH; i++) begin : g_ent
                localparam logic [ADDR_W-1:0] A = ADDR_W'(i);
                assign tbl[i] = decode(A[ADDR_W-1], A[ADDR_W-2:OPC_W], A[OPC_W-1:0]);
            end
            assign word = tbl[addr];
        end else begin : g_logic
            always_comb word = decode(addr[ADDR_W-1], addr[ADDR_W-2:OPC_W], addr[OPC_W-1:0]);
        end
    endgenerate

endmodule

// File: rtl/ctl_state.sv
module ctl_state
    import seqctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           stop,
    input  logic           cyc_clr,
    input  logic           fetch_next,
    output logic           phase,
    output logic [T_W-1:0] cycle,
    output logic           halted
);
    logic freeze;
    assign freeze = stop | halted;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= 1'b1;
            cycle  <= '0;
            halted <= 1'b0;
        end else if (!freeze) begin
            phase <= fetch_next;
            cycle <= cyc_clr ? '0 : cycle + 1'b1;
        end else begin
            halted <= 1'b1;
        end
    end

    // R4
    cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stop && !halted && !cyc_clr) |=> (cycle == T_W'($past(cycle) + 1'b1)));

    // R9
    cyc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!stop && !halted && cyc_clr) |=> (cycle == '0));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(cycle) && $stable(phase)));

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
    import seqctl_pkg::*;
#(
    parameter bit USE_TABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode_i,
    output logic              stop_o,
    output logic              cyc_clr_o,
    output logic              fetch_next_o,
    output logic [1:0]        pc_sel_o,
    output logic [1:0]        pc_wr_o,
    output logic              addr_sel_o,
    output logic              mem_we_o,
    output logic              ir_we_o,
    output logic              opnd_we_o,
    output logic [2:0]        wb_sel_o,
    output logic              rf_we_o,
    output logic              alub_sel_o,
    output logic              rd2_sel_o,
    output logic [3:0]        alu_fn_o,
    output logic              res_we_o,
    output logic              lo_we_o,
    output logic              hi_we_o,
    output logic [WORD_W-1:0] ctl_word_o,
    output logic              phase_fetch_o,
    output logic [T_W-1:0]    cycle_o
);
    logic           phase;
    logic [T_W-1:0] cycle;
    logic           halted;
    ctl_t           raw;
    ctl_t           eff;

    ctl_rom #(.USE_TABLE(USE_TABLE)) u_rom (
        .fetch (phase),
        .cyc   (cycle),
        .op    (opcode_i),
        .word  (raw)
    );

    assign eff = halted ? ctl_halt() : raw;

    ctl_state u_state (
        .clk        (clk),
        .rst        (rst),
        .stop       (eff.stop),
        .cyc_clr    (eff.cyc_clr),
        .fetch_next (eff.fetch_next),
        .phase      (phase),
        .cycle      (cycle),
        .halted     (halted)
    );

    assign stop_o        = eff.stop;
    assign cyc_clr_o     = eff.cyc_clr;
    assign fetch_next_o  = eff.fetch_next;
    assign pc_sel_o      = eff.pc_sel;
    assign pc_wr_o       = eff.pc_wr;
    assign addr_sel_o    = eff.addr_sel;
    assign mem_we_o      = eff.mem_we;
    assign ir_we_o       = eff.ir_we;
    assign opnd_we_o     = eff.opnd_we;
    assign wb_sel_o      = eff.wb_sel;
    assign rf_we_o       = eff.rf_we;
    assign alub_sel_o    = eff.alub_sel;
    assign rd2_sel_o     = eff.rd2_sel;
    assign alu_fn_o      = eff.alu_fn;
    assign res_we_o      = eff.res_we;
    assign lo_we_o       = eff.lo_we;
    assign hi_we_o       = eff.hi_we;
    assign ctl_word_o    = eff;
    assign phase_fetch_o = phase;
    assign cycle_o       = cycle;

    // R2
    fetch_t0_chk: assert property (@(posedge clk) disable iff (rst)
        (phase && cycle == '0) |-> (ir_we_o && !addr_sel_o && fetch_next_o));

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> !(ir_we_o || opnd_we_o || rf_we_o || res_we_o || mem_we_o || lo_we_o || hi_we_o));

    // R3
    fetch_end_chk: assert property (@(posedge clk) disable iff (rst)
        (phase && cycle == 4'd3) |=> (!phase_fetch_o && cycle_o == 4'd4));

endmodule

// File: tb/sim_ctl_sequencer.sv
module sim_ctl_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  opcode_i = '0;
    logic        stop_o, cyc_clr_o, fetch_next_o;
    logic [1:0]  pc_sel_o, pc_wr_o;
    logic        addr_sel_o, mem_we_o, ir_we_o, opnd_we_o;
    logic [2:0]  wb_sel_o;
    logic        rf_we_o, alub_sel_o, rd2_sel_o;
    logic [3:0]  alu_fn_o;
    logic        res_we_o, lo_we_o, hi_we_o;
    logic [24:0] ctl_word_o;
    logic        phase_fetch_o;
    logic [3:0]  cycle_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ctl_sequencer u0 (.*);

    function automatic logic [24:0] exp_w(bit ph, int c, int op);
        logic [24:0] w = '0;
        if (ph) begin
            case (c)
                0: begin w[15] = 1'b1; w[22] = 1'b1; end
                1: begin w[19:18] = 2'b01; w[22] = 1'b1; end
                2: begin w[14] = 1'b1; w[22] = 1'b1; end
                3: w[19:18] = 2'b01;
                default: begin w[23] = 1'b1; w[22] = 1'b1; end
            endcase
        end else if (op == 25 && c == 4) begin
            w[3] = 1'b1; w[9] = 1'b1;
        end else if (op == 25 && c == 5) begin
            w[17] = 1'b1; w[13:11] = 3'b101; w[10] = 1'b1; w[23] = 1'b1; w[22] = 1'b1;
        end else if (op == 0 && c == 4) begin
            w[3] = 1'b1;
        end else if (op == 0 && c == 5) begin
            w[10] = 1'b1; w[23] = 1'b1; w[22] = 1'b1;
        end else if (op == 31 && c == 4) begin
            w[24] = 1'b1;
        end else begin
            w[23] = 1'b1; w[22] = 1'b1;
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_word(input logic [24:0] e, input string req);
        logic [24:0] fields;
        fields = {stop_o, cyc_clr_o, fetch_next_o, pc_sel_o, pc_wr_o, addr_sel_o,
                  mem_we_o, ir_we_o, opnd_we_o, wb_sel_o, rf_we_o, alub_sel_o,
                  rd2_sel_o, alu_fn_o, res_we_o, lo_we_o, hi_we_o, 1'b0};
        chk(ctl_word_o == e, req, ctl_word_o, e);
        chk(fields == ctl_word_o, "R10 field packing", fields, ctl_word_o);
    endtask

    task automatic chk_state(input bit ph, input int c, input string req);
        chk(phase_fetch_o == ph, req, phase_fetch_o, ph);
        chk(cycle_o == 4'(c), req, cycle_o, c);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        #0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int op = 0; op < 32; op++) begin
            opcode_i = 5'(op);
            do_reset();
            #1;
            // R1 reset state
            chk_state(1'b1, 0, "R1 reset");
            chk(stop_o == 1'b0, "R1 no halt", stop_o, 0);
            // R2, R3, R7 fetch sequence independent of opcode
            for (int c = 0; c < 4; c++) begin
                chk_word(exp_w(1'b1, c, op), c == 0 ? "R2 fetch t0 (R7)" : "R3 fetch step (R7)");
                chk_state(1'b1, c, "R4 fetch count");
                step();
            end
            // R4 execute starts at cycle 4
            chk_state(1'b0, 4, "R4 exec start");
            chk_word(exp_w(1'b0, 4, op),
                     op == 25 ? "R5 lw t4" : op == 0 ? "R6 add t4" : op == 31 ? "R8 halt t4" : "R9 undefined t4");
            if (op == 31) begin
                for (int k = 0; k < 3; k++) begin
                    step();
                    chk_state(1'b0, 4, "R8 frozen state");
                    chk_word(25'h1000000, "R8 halt held");
                end
            end else if (op == 25 || op == 0) begin
                step();
                chk_state(1'b0, 5, "R4 exec t5");
                chk_word(exp_w(1'b0, 5, op), op == 25 ? "R5 lw t5" : "R6 add t5");
                step();
                chk_state(1'b1, 0, op == 25 ? "R5 back to fetch" : "R6 back to fetch");
                chk_word(exp_w(1'b1, 0, op), "R2 refetch");
            end else begin
                step();
                chk_state(1'b1, 0, "R9 recover to fetch");
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule